// File: doc/BRIEF.md
# 100BASE-X PCS Transmit Symbol Encoder

This block sits between a MAC's nibble-wide transmit interface and the symbol path of a 100 Mb/s line driver. On every 25 MHz transmit clock it samples the frame-enable, error and 4-bit data inputs. It then produces one 5-bit code group. With no frame in progress, the line carries the idle code group without a break.

When a frame begins, the block discards the first two data nibbles. It sends the two start-of-stream delimiter symbols in their place. Every nibble after that goes through the 4-bit to 5-bit data table. A nibble flagged as errored becomes the halt symbol instead. As soon as the frame enable drops, the output goes back to idle. The output is taken from a register, so each symbol appears exactly one clock after the inputs it was built from.

Top module: `pcs_tx_encoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `tx_sym` shows the idle code 5'b11111 after that edge.
- R2: When `tx_en` is low at an edge, `tx_sym` is 5'b11111 after that edge, whatever `tx_err` and `tx_nib` carry.
- R3: The first nibble sampled with `tx_en` high after idle produces the J symbol 5'b11000.
- R4: The second consecutive nibble with `tx_en` high produces the K symbol 5'b10001.
- R5: From the third consecutive `tx_en` nibble on, with `tx_err` low, nibble values 0 to 15 map to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101.
- R6: A data-phase nibble sampled with `tx_err` high produces the halt symbol 5'b00100. The nibble after it is encoded normally.
- R7: `tx_err` has no effect on the two delimiter symbols.
- R8: After `tx_en` falls, the output stays at idle. The next frame starts again with J then K.
- R9: Every symbol appears exactly one clock after the edge that sampled its inputs, and not earlier.
- R10: If `tx_en` drops before the delimiter pair is complete, the output goes to idle. The next frame starts with a full J/K pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz transmit symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_err | input | 1 | Transmit error flag for the current nibble |
| tx_nib | input | 4 | Transmit data nibble |
| tx_sym | output | 5 | Registered 5-bit code group to the line driver |

## Verification
The checker counts frame position itself, from `tx_en` alone. It relies on `tx_en`, `tx_err` and `tx_nib` being settled at every rising edge, and on no input taking an unknown value once reset is released. The bench meets this by changing inputs only on falling edges and by driving every input from the first cycle. The data-phase property accepts any code group other than the four control codes, which keeps it free of the encoding table.

// File: rtl/pcs_tx_pkg.sv
package pcs_tx_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = 5;
  localparam int NUM_NIB = 1 << NIB_W;

  localparam logic [SYM_W-1:0] CODE_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CODE_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CODE_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CODE_HALT = 5'b00100;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SECOND,
    PH_DATA
  } phase_t;

  typedef enum logic [2:0] {
    SEL_IDLE,
    SEL_J,
    SEL_K,
    SEL_DATA,
    SEL_HALT
  } sym_sel_t;

  function automatic logic [SYM_W-1:0] data_code(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pcs_tx_framer.sv
module pcs_tx_framer
  import pcs_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tx_en,
  input  logic     tx_err,
  output sym_sel_t sel
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = PH_IDLE;
    sel     = SEL_IDLE;
    if (tx_en) begin
      case (phase_q)
        PH_IDLE: begin
          sel     = SEL_J;
          phase_d = PH_SECOND;
        end
        PH_SECOND: begin
          sel     = SEL_K;
          phase_d = PH_DATA;
        end
        default: begin
          sel     = tx_err ? SEL_HALT : SEL_DATA;
          phase_d = PH_DATA;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end
endmodule

// File: rtl/pcs_tx_symbol_map.sv
module pcs_tx_symbol_map
  import pcs_tx_pkg::*;
(
  input  sym_sel_t         sel,
  input  logic [NIB_W-1:0] nib,
  output logic [SYM_W-1:0] code
);
  always_comb begin
    case (sel)
      SEL_J:    code = CODE_J;
      SEL_K:    code = CODE_K;
      SEL_DATA: code = data_code(nib);
      SEL_HALT: code = CODE_HALT;
      default:  code = CODE_IDLE;
    endcase
  end
endmodule

// File: rtl/pcs_tx_encoder.sv
module pcs_tx_encoder
  import pcs_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             tx_err,
  input  logic [NIB_W-1:0] tx_nib,
  output logic [SYM_W-1:0] tx_sym
);
  sym_sel_t         sel;
  logic [SYM_W-1:0] code;

  pcs_tx_framer u_framer (
    .clk    (clk),
    .rst    (rst),
    .tx_en  (tx_en),
    .tx_err (tx_err),
    .sel    (sel)
  );

  pcs_tx_symbol_map u_map (
    .sel  (sel),
    .nib  (tx_nib),
    .code (code)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_sym <= CODE_IDLE;
    else     tx_sym <= code;
  end
endmodule

// File: rtl/pcs_tx_encoder_chk.sv
module pcs_tx_encoder_chk
  import pcs_tx_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             tx_en,
  input logic             tx_err,
  input logic [NIB_W-1:0] tx_nib,
  input logic [SYM_W-1:0] tx_sym
);
  logic [1:0] pos;

  always_ff @(posedge clk) begin
    if (rst || !tx_en) pos <= 2'd0;
    else if (pos != 2'd2) pos <= pos + 2'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> tx_sym == CODE_IDLE);

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> tx_sym == CODE_IDLE);

  p_start_j_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_en && pos == 2'd0) |=> tx_sym == CODE_J);

  p_second_k_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_en && pos == 2'd1) |=> tx_sym == CODE_K);

  p_data_code_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !tx_err && pos == 2'd2) |=>
      (tx_sym != CODE_IDLE && tx_sym != CODE_J && tx_sym != CODE_K && tx_sym != CODE_HALT));

  p_halt_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_en && tx_err && pos == 2'd2) |=> tx_sym == CODE_HALT);

  p_nib_unknown_free_r9: assert property (@(posedge clk) disable iff (rst)
    tx_en |-> !$isunknown(tx_nib));
endmodule

bind pcs_tx_encoder pcs_tx_encoder_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .tx_en  (tx_en),
  .tx_err (tx_err),
  .tx_nib (tx_nib),
  .tx_sym (tx_sym)
);

// File: tb/pcs_tx_encoder_test.sv
module pcs_tx_encoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       tx_err = 1'b0;
  logic [3:0] tx_nib = 4'h0;
  logic [4:0] tx_sym;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [4:0] E_IDLE = 5'b11111;
  localparam logic [4:0] E_J    = 5'b11000;
  localparam logic [4:0] E_K    = 5'b10001;
  localparam logic [4:0] E_HALT = 5'b00100;
  localparam logic [4:0] E_TAB [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                        5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                        5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                        5'b11010, 5'b11011, 5'b11100, 5'b11101};

  always #10 clk = ~clk;

  pcs_tx_encoder uut (
    .clk    (clk),
    .rst    (rst),
    .tx_en  (tx_en),
    .tx_err (tx_err),
    .tx_nib (tx_nib),
    .tx_sym (tx_sym)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: tx_sym=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic er, input logic [3:0] d,
                      input logic [4:0] exp, input string tag);
    @(negedge clk);
    tx_en = en; tx_err = er; tx_nib = d;
    @(posedge clk);
    #1 check(tag, tx_sym, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; tx_en = 1'b1; tx_nib = 4'h5;
    @(posedge clk);
    #1 check("R1 reset", tx_sym, E_IDLE);
    @(negedge clk);
    rst = 1'b0; tx_en = 1'b0;
  endtask

  task automatic t_idle;
    step(1'b0, 1'b0, 4'h0, E_IDLE, "R2 idle");
    step(1'b0, 1'b1, 4'hA, E_IDLE, "R2 idle err");
    step(1'b0, 1'b0, 4'hF, E_IDLE, "R2 idle nib");
  endtask

  task automatic t_latency;
    @(negedge clk);
    tx_en = 1'b1; tx_err = 1'b0; tx_nib = 4'h3;
    #5 check("R9 before edge", tx_sym, E_IDLE);
    @(posedge clk);
    #1 check("R9 after edge", tx_sym, E_J);
    step(1'b1, 1'b0, 4'h3, E_K, "R4 K");
    step(1'b1, 1'b0, 4'h3, E_TAB[3], "R9 data");
    step(1'b0, 1'b0, 4'h3, E_IDLE, "R8 end");
  endtask

  task automatic t_all_nibbles;
    step(1'b1, 1'b0, 4'h7, E_J, "R3 J");
    step(1'b1, 1'b0, 4'h9, E_K, "R4 K");
    for (int i = 0; i < 16; i++)
      step(1'b1, 1'b0, 4'(i), E_TAB[i], "R5 table");
    for (int i = 15; i >= 0; i--)
      step(1'b1, 1'b0, 4'(i), E_TAB[i], "R5 table rev");
    step(1'b0, 1'b0, 4'h6, E_IDLE, "R8 idle after");
    step(1'b0, 1'b0, 4'h6, E_IDLE, "R8 idle hold");
  endtask

  task automatic t_error;
    step(1'b1, 1'b0, 4'h0, E_J, "R3 J");
    step(1'b1, 1'b0, 4'h0, E_K, "R4 K");
    step(1'b1, 1'b0, 4'h2, E_TAB[2], "R5 data");
    step(1'b1, 1'b1, 4'h2, E_HALT, "R6 halt");
    step(1'b1, 1'b0, 4'hC, E_TAB[12], "R6 after halt");
    step(1'b1, 1'b1, 4'hF, E_HALT, "R6 halt2");
    step(1'b0, 1'b1, 4'hF, E_IDLE, "R2 err no en");
  endtask

  task automatic t_err_in_ssd;
    step(1'b1, 1'b1, 4'h4, E_J, "R7 err on J");
    step(1'b1, 1'b1, 4'h4, E_K, "R7 err on K");
    step(1'b1, 1'b0, 4'h4, E_TAB[4], "R7 data after");
    step(1'b0, 1'b0, 4'h0, E_IDLE, "R8 end");
  endtask

  task automatic t_abort;
    step(1'b1, 1'b0, 4'h1, E_J, "R10 J");
    step(1'b0, 1'b0, 4'h1, E_IDLE, "R10 abort");
    step(1'b1, 1'b0, 4'h1, E_J, "R10 restart J");
    step(1'b1, 1'b0, 4'h1, E_K, "R10 restart K");
    step(1'b1, 1'b0, 4'h8, E_TAB[8], "R10 data");
    step(1'b0, 1'b0, 4'h0, E_IDLE, "R8 end");
  endtask

  task automatic t_back_to_back;
    step(1'b1, 1'b0, 4'hB, E_J, "R8 f1 J");
    step(1'b1, 1'b0, 4'hB, E_K, "R8 f1 K");
    step(1'b1, 1'b0, 4'hB, E_TAB[11], "R8 f1 data");
    step(1'b0, 1'b0, 4'hB, E_IDLE, "R8 gap");
    step(1'b1, 1'b0, 4'hD, E_J, "R8 f2 J");
    step(1'b1, 1'b0, 4'hD, E_K, "R8 f2 K");
    step(1'b1, 1'b0, 4'hD, E_TAB[13], "R8 f2 data");
    step(1'b0, 1'b0, 4'h0, E_IDLE, "R8 end");
  endtask

  task automatic t_reset_mid_frame;
    step(1'b1, 1'b0, 4'h5, E_J, "R1 pre J");
    step(1'b1, 1'b0, 4'h5, E_K, "R1 pre K");
    t_reset;
    step(1'b1, 1'b0, 4'h5, E_J, "R1 post reset J");
    step(1'b0, 1'b0, 4'h5, E_IDLE, "R1 post end");
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset;
    t_idle;
    t_latency;
    t_all_nibbles;
    t_error;
    t_err_in_ssd;
    t_abort;
    t_back_to_back;
    t_reset_mid_frame;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule